// File: doc/BRIEF.md
# Four-level page table walker

This block translates a 64-bit virtual address into a physical address by walking a four-level radix tree of page tables in memory. It reads one 8-byte entry per level and checks the permission flags of each entry. The walk stops at the first entry that denies the access. A caller hands it a virtual address, the base of the root table, and two flags: one for a write access and one for an unprivileged access. Some cycles later it reports a one-cycle done pulse. The pulse carries either the physical address or a fault, together with the level at which the walk ended.

Both streaming edges use valid/ready. A translation request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle, so the caller holds its request until then. On the memory side, the walker raises `mem_req_valid` and keeps it and `mem_req_addr` steady until the memory accepts them with `mem_req_ready`. It then waits for one `mem_rsp_valid` beat, which may come after any delay. Only one read is ever in flight. The response side has no back-pressure: a beat that arrives while no read is pending is ignored. `busy`, `done` and the result pins are plain status.

Top module: `ptw_walker`

## Requirements
- R1: A walk that passes every check ends with `done` high, `done_fault` low and `done_level` = 4. `done_paddr` equals the level-4 entry with bits 11:0 cleared, plus virtual address bits 11:0.
- R2: The entry read at each level is at table base + 8 × index, so `mem_req_addr` bits 2:0 are zero. The index is virtual address bits 47:39 at level 1, 38:30 at level 2, 29:21 at level 3 and 20:12 at level 4.
- R3: Reads go strictly in the order level 1, 2, 3, 4. The base of each next table is the fetched entry with bits 11:0 cleared. A successful walk makes exactly four reads.
- R4: Virtual address bits 63:48 have no effect on the reads made or on the result.
- R5: An entry whose present flag (bit 0) is clear ends the walk at that level with a fault. No further reads are made.
- R6: A write access to an entry whose writable flag (bit 1) is clear faults at that level. A read access does not look at the writable flag.
- R7: An unprivileged access to an entry whose user flag (bit 2) is clear faults at that level. A privileged access does not look at the user flag.
- R8: `done` is high for exactly one cycle per accepted request. On a fault, `done_level` gives the failing level (1 to 4) and `done_paddr` is zero.
- R9: `mem_req_valid` and `mem_req_addr` stay steady until accepted. At most one read is outstanding. The walker tolerates any memory stall or response latency.
- R10: `req_ready` is high only when idle. `busy` is high from the cycle after acceptance up to the done cycle. The root base is sampled at acceptance, and its bits 11:0 are treated as zero.
- R11: While the synchronous, active-high `rst` is high, the walker goes idle with `done`, `busy` and `mem_req_valid` low. This also aborts a walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root (level 1) table base |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is unprivileged |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a permission fault |
| done_level | output | 3 | Level at which the walk ended |
| done_paddr | output | 64 | Translated physical address (zero on fault) |

## Verification
The bench places a single denying entry at level 1, 2, 3 or 4 and looks at the read count and the reported level. A walker that fails to stop early would issue extra reads, and one that counts levels wrongly would report the wrong depth. It also pairs each flag with the access that should or should not care about it. A write to a read-only entry must fault while a read of it succeeds, and a kernel access to a non-user entry must succeed; confusing these checks shows up as a fault on the wrong side. Entries carry random junk in bits 11:3, and roots carry junk in their low bits. A design that fails to clear them would read the wrong addresses or return a wrong physical address. A reset in the middle of a walk, and random memory stalls and latencies, probe whether the request is held steady and whether the walker waits correctly.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2
  } wk_state_e;

  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_WRITE   = 1;
  localparam int FLAG_USER    = 2;
  localparam int FLAG_BITS    = 3;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int LEVELS   = 4,
  parameter int IDX_BITS = 9,
  parameter int OFF_BITS = 12,
  parameter int VA_BITS  = OFF_BITS + IDX_BITS * LEVELS,
  parameter int LVL_W    = $clog2(LEVELS + 1)
) (
  input  logic [VA_BITS-1:0]  vaddr,
  input  logic [LVL_W-1:0]    lvl,
  output logic [IDX_BITS-1:0] idx
);
  logic [IDX_BITS-1:0] idx_arr [1:LEVELS];
  logic unused_low;
  assign unused_low = ^vaddr[OFF_BITS-1:0];

  // Level 1 takes the highest index field, level LEVELS the lowest.
  for (genvar g = 1; g <= LEVELS; g++) begin : g_field
    assign idx_arr[g] = vaddr[OFF_BITS + IDX_BITS*(LEVELS-g+1) - 1 -: IDX_BITS];
  end

  always_comb begin
    idx = '0;
    for (int k = 1; k <= LEVELS; k++) begin
      if (lvl == LVL_W'(k)) idx = idx_arr[k];
    end
  end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [FLAG_BITS-1:0] flags,
  input  logic                 is_write,
  input  logic                 is_user,
  output logic                 fault
);
  always_comb begin
    fault = 1'b0;
    if (!flags[FLAG_PRESENT])             fault = 1'b1;
    if (is_write && !flags[FLAG_WRITE])   fault = 1'b1;
    if (is_user && !flags[FLAG_USER])     fault = 1'b1;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int LEVELS   = 4,
  parameter int IDX_BITS = 9,
  parameter int OFF_BITS = 12,
  parameter int ENT_LOG2 = 3,
  localparam int LVL_W   = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] req_root,
  input  logic              req_write,
  input  logic              req_user,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              done_fault,
  output logic [LVL_W-1:0]  done_level,
  output logic [ADDR_W-1:0] done_paddr
);
  localparam int VA_BITS = OFF_BITS + IDX_BITS * LEVELS;

  wk_state_e           state_q;
  logic [LVL_W-1:0]    lvl_q;
  logic [ADDR_W-1:0]   base_q;
  logic [VA_BITS-1:0]  va_q;
  logic                wr_q, usr_q;
  logic                done_q, fault_q;
  logic [LVL_W-1:0]    dlvl_q;
  logic [ADDR_W-1:0]   paddr_q;

  logic [IDX_BITS-1:0] cur_idx;
  logic                perm_fault;
  logic [ADDR_W-1:0]   next_base;
  logic                unused_bits;

  assign unused_bits = ^{req_vaddr[ADDR_W-1:VA_BITS], req_root[OFF_BITS-1:0],
                         mem_rsp_data[OFF_BITS-1:FLAG_BITS]};

  ptw_index_sel #(
    .LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .OFF_BITS(OFF_BITS),
    .VA_BITS(VA_BITS), .LVL_W(LVL_W)
  ) u_idx (
    .vaddr(va_q), .lvl(lvl_q), .idx(cur_idx)
  );

  ptw_perm_check u_perm (
    .flags(mem_rsp_data[FLAG_BITS-1:0]), .is_write(wr_q), .is_user(usr_q),
    .fault(perm_fault)
  );

  assign next_base     = {mem_rsp_data[ADDR_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
  assign req_ready     = (state_q == WK_IDLE);
  assign busy          = (state_q != WK_IDLE);
  assign mem_req_valid = (state_q == WK_ISSUE);
  assign mem_req_addr  = base_q + (ADDR_W'(cur_idx) << ENT_LOG2);
  assign done          = done_q;
  assign done_fault    = fault_q;
  assign done_level    = dlvl_q;
  assign done_paddr    = paddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WK_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      dlvl_q  <= '0;
      paddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        WK_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr[VA_BITS-1:0];
            base_q  <= {req_root[ADDR_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
            wr_q    <= req_write;
            usr_q   <= req_user;
            lvl_q   <= LVL_W'(1);
            state_q <= WK_ISSUE;
          end
        end
        WK_ISSUE: begin
          if (mem_req_ready) state_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (mem_rsp_valid) begin
            if (perm_fault) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              dlvl_q  <= lvl_q;
              paddr_q <= '0;
              state_q <= WK_IDLE;
            end else if (lvl_q == LVL_W'(LEVELS)) begin
              done_q  <= 1'b1;
              fault_q <= 1'b0;
              dlvl_q  <= lvl_q;
              paddr_q <= next_base + ADDR_W'(va_q[OFF_BITS-1:0]);
              state_q <= WK_IDLE;
            end else begin
              base_q  <= next_base;
              lvl_q   <= lvl_q + 1'b1;
              state_q <= WK_ISSUE;
            end
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rsp_valid)); // R8
  AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    done && done_fault |-> done_level >= LVL_W'(1) && done_level <= LVL_W'(LEVELS)); // R8
  AST_SUCCESS_DEPTH: assert property (@(posedge clk) disable iff (rst)
    done && !done_fault |-> done_level == LVL_W'(LEVELS)); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> busy && !req_ready); // R10
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [63:0] req_root = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic        done_fault;
  logic [2:0]  done_level;
  logic [63:0] done_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root),
    .req_write(req_write), .req_user(req_user), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_fault(done_fault), .done_level(done_level),
    .done_paddr(done_paddr)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // Memory contents are a hash of the address; flags may be overridden per level.
  logic [63:0] key = 64'h0123_4567_89AB_CDEF;
  bit          force7 = 1'b1;
  int          ovr_lvl = 0;
  logic [2:0]  ovr_flags = 3'b111;

  function automatic logic [63:0] mix(input logic [63:0] a);
    logic [63:0] h;
    h = (a ^ key) * 64'h9E37_79B9_7F4A_7C15;
    h = h ^ (h >> 29);
    h = h * 64'hBF58_476D_1CE4_E5B9;
    return h ^ (h >> 31);
  endfunction

  function automatic logic [63:0] ent(input logic [63:0] a, input int lvl);
    logic [63:0] h;
    logic [2:0]  f;
    h = mix(a);
    f = force7 ? 3'b111 : h[2:0];
    if (lvl == ovr_lvl) f = ovr_flags;
    return {h[63:3], f};
  endfunction

  // Expected walk
  logic [63:0] exp_addr [0:3];
  int          exp_n;
  bit          exp_fault;
  int          exp_lvl;
  logic [63:0] exp_pa;

  task automatic model(input logic [63:0] va, input logic [63:0] root,
                       input bit wr, input bit us);
    logic [63:0] base, e, a, idx;
    base = root & ~64'hFFF;
    exp_fault = 1'b0; exp_n = 0; exp_lvl = 4; exp_pa = '0;
    for (int l = 1; l <= 4; l++) begin
      idx = (va >> (39 - 9*(l-1))) & 64'h1FF;
      a = base + (idx << 3);
      exp_addr[l-1] = a;
      exp_n = l;
      e = ent(a, l);
      if (!e[0] || (wr && !e[1]) || (us && !e[2])) begin
        exp_fault = 1'b1; exp_lvl = l;
        return;
      end
      base = e & ~64'hFFF;
    end
    exp_pa = base + (va & 64'hFFF);
  endtask

  // Memory model
  bit          hs = 1'b0;
  logic [63:0] hs_addr = '0;
  int          rd_cnt = 0;
  logic [63:0] rd_log [0:15];
  int          rsp_cnt = 0;
  int          txn_rsp0 = 0;
  bit          pend = 1'b0;
  logic [63:0] pend_addr = '0;
  int          lat = 0;

  always @(posedge clk) begin
    hs      <= mem_req_valid && mem_req_ready && !rst;
    hs_addr <= mem_req_addr;
    if (mem_req_valid && mem_req_ready && !rst) begin
      rd_log[rd_cnt % 16] <= mem_req_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_req_ready = ($urandom % 3) != 0;
    if (rst) begin
      pend = 1'b0;
    end else begin
      if (hs) begin
        pend = 1'b1; pend_addr = hs_addr; lat = $urandom % 4;
      end
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = ent(pend_addr, rsp_cnt - txn_rsp0 + 1);
          rsp_cnt = rsp_cnt + 1;
          pend = 1'b0;
        end else begin
          lat = lat - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [63:0] last_pa;

  task automatic run(input logic [63:0] va, input logic [63:0] root,
                     input bit wr, input bit us, input string ftag);
    int base_rd, k;
    model(va, root, wr, us);
    @(negedge clk);
    txn_rsp0 = rsp_cnt;
    base_rd  = rd_cnt;
    chk(req_ready, "R10", "ready when idle", {63'b0, req_ready}, 64'd1);
    req_valid = 1'b1; req_vaddr = va; req_root = root;
    req_write = wr; req_user = us;
    @(negedge clk);
    req_valid = 1'b0;
    req_root  = {$urandom, $urandom};
    req_vaddr = {$urandom, $urandom};
    chk(busy && !req_ready, "R10", "busy after accept", {62'b0, busy, req_ready}, 64'd2);
    k = 0;
    while (!done && k < 500) begin
      @(negedge clk);
      k++;
    end
    chk(done, "R8", "done seen", {63'b0, done}, 64'd1);
    chk(done_fault == exp_fault, ftag, "fault flag", {63'b0, done_fault}, {63'b0, exp_fault});
    chk(done_level == 3'(exp_lvl), ftag, "end level", {61'b0, done_level}, 64'(exp_lvl));
    chk(done_paddr == exp_pa, exp_fault ? "R8" : "R1", "paddr", done_paddr, exp_pa);
    chk(!busy, "R10", "idle at done", {63'b0, busy}, 64'd0);
    chk(rd_cnt - base_rd == exp_n, "R3", "read count (R9 stalls)", 64'(rd_cnt - base_rd), 64'(exp_n));
    for (int i = 0; i < exp_n; i++)
      chk(rd_log[(base_rd + i) % 16] == exp_addr[i], "R2", "entry address",
          rd_log[(base_rd + i) % 16], exp_addr[i]);
    last_pa = done_paddr;
    @(negedge clk);
    chk(!done, "R8", "done one cycle", {63'b0, done}, 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] va0, pa0;
    void'($urandom(32'd7531));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !mem_req_valid, "R11", "reset outputs",
        {61'b0, busy, done, mem_req_valid}, 64'd0);
    rst = 1'b0;

    // R1 full success
    va0 = 64'h0000_7F12_3456_789A;
    force7 = 1'b1; ovr_lvl = 0;
    run(va0, 64'h0000_0000_4000_0000, 1'b1, 1'b1, "R1");
    pa0 = last_pa;
    // R4 upper bits ignored
    run(va0 | 64'hFFFF_0000_0000_0000, 64'h0000_0000_4000_0000, 1'b1, 1'b1, "R4");
    chk(last_pa == pa0, "R4", "same result with high bits", last_pa, pa0);
    // R10 root low bits ignored
    run(va0, 64'h0000_0000_4000_0ABC, 1'b0, 1'b0, "R10");
    chk(last_pa == pa0, "R10", "root low bits ignored", last_pa, pa0);
    // R5 present clear at level 2 and 4
    ovr_lvl = 2; ovr_flags = 3'b110;
    run(va0, 64'h0000_0000_8000_0000, 1'b0, 1'b0, "R5");
    ovr_lvl = 4; ovr_flags = 3'b000;
    run(va0, 64'h0000_0000_8000_0000, 1'b0, 1'b0, "R5");
    // R6 write to read-only at level 3; read passes
    ovr_lvl = 3; ovr_flags = 3'b101;
    run(va0, 64'h0000_0001_0000_0000, 1'b1, 1'b0, "R6");
    run(va0, 64'h0000_0001_0000_0000, 1'b0, 1'b1, "R6");
    // R7 non-user at level 1: unprivileged faults, privileged passes
    ovr_lvl = 1; ovr_flags = 3'b011;
    run(va0, 64'h0000_0002_0000_0000, 1'b0, 1'b1, "R7");
    run(va0, 64'h0000_0002_0000_0000, 1'b1, 1'b0, "R7");

    // R11 reset in the middle of a walk
    ovr_lvl = 0; force7 = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va0; req_root = 64'h1000;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req_valid && req_ready, "R11", "reset aborts walk",
        {60'b0, busy, done, mem_req_valid, req_ready}, 64'd1);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Random walks
    for (int t = 0; t < 300; t++) begin
      key    = {$urandom, $urandom};
      force7 = ($urandom % 2) == 0;
      ovr_lvl = (($urandom % 4) == 0) ? int'($urandom % 4) + 1 : 0;
      ovr_flags = 3'($urandom);
      run({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 1'($urandom), "R1");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule